// File: doc/BRIEF.md
# Oversampling Asynchronous Serial Receiver with Break Handling

This block receives asynchronous serial frames on a single input line. It is clocked by the system clock. All bit timing advances only on cycles where a base-tick enable is high, and that tick is expected at sixteen times the bit rate. Each frame has a low start bit, eight data bits sent least significant bit first, an optional parity bit and one stop bit. A completed frame is placed in a data register and a full flag is raised. Software lowers the full flag with a strobe once it has taken the byte.

Three error flags (overrun, framing, parity) are sticky. Each one falls only when its own clear strobe is pulsed. When the line is held low continuously (a break), the receiver keeps cycling through all-zero frames. A framing error that software clears is therefore raised again by the next such frame. Dropping the receive enable halts reception but leaves the data register and every flag as they were.

Top module: `uart_ovs_rx`

## Requirements
- R1: After reset, rx_full, err_ovr, err_fer and err_per are 0 and rx_data is 0.
- R2: While idle, a low level on the synchronized line at a tick starts a frame. Eight data bits are taken least significant bit first, and when the stop bit has been sampled the byte is loaded into rx_data and rx_full is set to 1.
- R3: The start bit is re-sampled 8 ticks after it is recognized, and each later bit is sampled 16 ticks after the previous one. If the line is high at the start re-sample, the receiver returns to idle and no frame is produced.
- R4: With par_en=1, a parity bit follows the data bits. par_odd=1 selects odd parity (data ones plus parity bit is odd) and par_odd=0 selects even. A mismatch sets err_per. With par_en=0 there is no parity bit and err_per is not set.
- R5: A stop bit sampled low sets err_fer, and the byte is still loaded.
- R6: A frame that completes while rx_full is 1 sets err_ovr and leaves rx_data, err_fer and err_per unchanged.
- R7: err_ovr, err_fer and err_per stay set until their own strobe (clr_ovr, clr_fer, clr_per) is pulsed. The strobe of another flag does not clear them.
- R8: While the line stays low, the receiver keeps producing all-zero frames. After clr_fer (and clr_full), err_fer is set again by the next frame.
- R9: With rx_en=0, no frame is received, and rx_data, rx_full and the error flags keep their values.
- R10: A clr_full pulse clears rx_full when no frame completes in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| tick | input | 1 | Base-tick enable, 16x bit rate |
| rxd | input | 1 | Serial line, idle high |
| rx_en | input | 1 | Receive enable |
| par_en | input | 1 | Parity bit present and checked |
| par_odd | input | 1 | 1 odd parity, 0 even parity |
| clr_full | input | 1 | Clear strobe for rx_full |
| clr_ovr | input | 1 | Clear strobe for err_ovr |
| clr_fer | input | 1 | Clear strobe for err_fer |
| clr_per | input | 1 | Clear strobe for err_per |
| rx_data | output | 8 | Received byte |
| rx_full | output | 1 | Data register holds an unread byte |
| err_ovr | output | 1 | Sticky overrun flag |
| err_fer | output | 1 | Sticky framing error flag |
| err_per | output | 1 | Sticky parity error flag |

## Verification
The bench builds the block with its default parameters: sixteen ticks per bit, eight data bits and a two-stage synchronizer. It asserts tick on every other clock, so one bit lasts 32 clocks and a whole frame fits in a few hundred cycles. With this timing, a short glitch of four ticks falls clearly before the start re-sample, so the abort path can be reached. A held-low line covers two back-to-back break frames in about 700 cycles, which is enough to see the framing flag set again after a clear.

// File: rtl/uart_ovs_rx_pkg.sv
package uart_ovs_rx_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_START = 3'd1,
    ST_DATA  = 3'd2,
    ST_PAR   = 3'd3,
    ST_STOP  = 3'd4
  } rx_state_e;

  function automatic int mid_tick(input int ovs);
    return ovs / 2;
  endfunction
endpackage

// File: rtl/uart_ovs_sync.sv
module uart_ovs_sync #(
  parameter int  STAGES    = 2,
  parameter logic RESET_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] chain_q;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[0] <= RESET_VAL;
          else        chain_q[0] <= din;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[i] <= RESET_VAL;
          else        chain_q[i] <= chain_q[i-1];
        end
      end
    end
  endgenerate

  assign dout = chain_q[STAGES-1];
endmodule

// File: rtl/uart_ovs_engine.sv
module uart_ovs_engine
  import uart_ovs_rx_pkg::*;
#(
  parameter int DW  = 8,
  parameter int OVS = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          rx_en,
  input  logic          line_s,
  input  logic          par_en,
  input  logic          par_odd,
  output logic          frame_done,
  output logic [DW-1:0] frame_data,
  output logic          frame_stop_bad,
  output logic          frame_par_bad,
  output rx_state_e     state_o
);
  localparam int CNT_W = $clog2(OVS + 1);
  localparam int IDX_W = (DW > 1) ? $clog2(DW) : 1;
  localparam int MID   = mid_tick(OVS);

  rx_state_e        state_q;
  logic [CNT_W-1:0] cnt_q;
  logic [IDX_W-1:0] idx_q;
  logic [DW-1:0]    shreg_q;
  logic             par_bit_q;
  logic             done_q, stop_bad_q, par_bad_q;

  // named internal events
  logic at_mid, at_full, stop_sample, start_abort;
  assign at_mid      = tick && (cnt_q == CNT_W'(MID));
  assign at_full     = tick && (cnt_q == CNT_W'(OVS));
  assign stop_sample = rx_en && (state_q == ST_STOP) && at_full;
  assign start_abort = rx_en && (state_q == ST_START) && at_mid && line_s;

  function automatic logic parity_of(input logic [DW-1:0] d, input logic odd);
    return (^d) ^ odd;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      cnt_q     <= '0;
      idx_q     <= '0;
      shreg_q   <= '0;
      par_bit_q <= 1'b0;
    end else if (!rx_en) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
    end else if (tick) begin
      unique case (state_q)
        ST_IDLE: begin
          if (!line_s) begin
            state_q <= ST_START;
            cnt_q   <= CNT_W'(1);
          end
        end
        ST_START: begin
          if (cnt_q == CNT_W'(MID)) begin
            if (line_s) begin
              state_q <= ST_IDLE;
            end else begin
              state_q <= ST_DATA;
              idx_q   <= '0;
            end
            cnt_q <= CNT_W'(1);
          end else begin
            cnt_q <= cnt_q + CNT_W'(1);
          end
        end
        ST_DATA: begin
          if (cnt_q == CNT_W'(OVS)) begin
            shreg_q <= {line_s, shreg_q[DW-1:1]};
            cnt_q   <= CNT_W'(1);
            if (idx_q == IDX_W'(DW - 1)) state_q <= par_en ? ST_PAR : ST_STOP;
            else                        idx_q   <= idx_q + IDX_W'(1);
          end else begin
            cnt_q <= cnt_q + CNT_W'(1);
          end
        end
        ST_PAR: begin
          if (cnt_q == CNT_W'(OVS)) begin
            par_bit_q <= line_s;
            state_q   <= ST_STOP;
            cnt_q     <= CNT_W'(1);
          end else begin
            cnt_q <= cnt_q + CNT_W'(1);
          end
        end
        ST_STOP: begin
          if (cnt_q == CNT_W'(OVS)) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
          end else begin
            cnt_q <= cnt_q + CNT_W'(1);
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_q     <= 1'b0;
      stop_bad_q <= 1'b0;
      par_bad_q  <= 1'b0;
    end else begin
      done_q <= stop_sample;
      if (stop_sample) begin
        stop_bad_q <= !line_s;
        par_bad_q  <= par_en && (par_bit_q != parity_of(shreg_q, par_odd));
      end
    end
  end

  assign frame_done     = done_q;
  assign frame_data     = shreg_q;
  assign frame_stop_bad = stop_bad_q;
  assign frame_par_bad  = par_bad_q;
  assign state_o        = state_q;

  a_r3_start_abort: assert property (@(posedge clk) disable iff (!rst_n)
    start_abort |=> (state_q == ST_IDLE));
  a_r9_disable_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_en |=> (state_q == ST_IDLE));
  a_r2_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);
endmodule

// File: rtl/uart_ovs_flags.sv
module uart_ovs_flags #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          frame_done,
  input  logic [DW-1:0] frame_data,
  input  logic          frame_stop_bad,
  input  logic          frame_par_bad,
  input  logic          clr_full,
  input  logic          clr_ovr,
  input  logic          clr_fer,
  input  logic          clr_per,
  output logic [DW-1:0] data_o,
  output logic          full_o,
  output logic          ovr_o,
  output logic          fer_o,
  output logic          per_o
);
  logic [DW-1:0] data_q;
  logic          full_q, ovr_q, fer_q, per_q;
  logic          load, overrun;

  assign load    = frame_done && !full_q;
  assign overrun = frame_done && full_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
      full_q <= 1'b0;
      ovr_q  <= 1'b0;
      fer_q  <= 1'b0;
      per_q  <= 1'b0;
    end else begin
      if (load) begin
        data_q <= frame_data;
        full_q <= 1'b1;
      end else if (clr_full) begin
        full_q <= 1'b0;
      end
      if (overrun)                     ovr_q <= 1'b1;
      else if (clr_ovr)                ovr_q <= 1'b0;
      if (load && frame_stop_bad)      fer_q <= 1'b1;
      else if (clr_fer)                fer_q <= 1'b0;
      if (load && frame_par_bad)       per_q <= 1'b1;
      else if (clr_per)                per_q <= 1'b0;
    end
  end

  assign data_o = data_q;
  assign full_o = full_q;
  assign ovr_o  = ovr_q;
  assign fer_o  = fer_q;
  assign per_o  = per_q;

  a_r6_ovr_on_full: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_done && full_q) |=> ovr_q);
  a_r6_data_kept: assert property (@(posedge clk) disable iff (!rst_n)
    full_q |=> $stable(data_q));
  a_r7_ovr_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (ovr_q && !clr_ovr) |=> ovr_q);
  a_r7_fer_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (fer_q && !clr_fer) |=> fer_q);
  a_r7_per_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (per_q && !clr_per) |=> per_q);
  a_r10_full_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_full && !frame_done) |=> !full_q);
endmodule

// File: rtl/uart_ovs_rx.sv
module uart_ovs_rx
  import uart_ovs_rx_pkg::*;
#(
  parameter int DW     = 8,
  parameter int OVS    = 16,
  parameter int SYNC_N = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          rxd,
  input  logic          rx_en,
  input  logic          par_en,
  input  logic          par_odd,
  input  logic          clr_full,
  input  logic          clr_ovr,
  input  logic          clr_fer,
  input  logic          clr_per,
  output logic [DW-1:0] rx_data,
  output logic          rx_full,
  output logic          err_ovr,
  output logic          err_fer,
  output logic          err_per
);
  logic          line_s;
  logic          frame_done, frame_stop_bad, frame_par_bad;
  logic [DW-1:0] frame_data;
  rx_state_e     eng_state;

  uart_ovs_sync #(.STAGES(SYNC_N), .RESET_VAL(1'b1)) u_sync (
    .clk(clk), .rst_n(rst_n), .din(rxd), .dout(line_s)
  );

  uart_ovs_engine #(.DW(DW), .OVS(OVS)) u_engine (
    .clk(clk), .rst_n(rst_n), .tick(tick), .rx_en(rx_en), .line_s(line_s),
    .par_en(par_en), .par_odd(par_odd),
    .frame_done(frame_done), .frame_data(frame_data),
    .frame_stop_bad(frame_stop_bad), .frame_par_bad(frame_par_bad),
    .state_o(eng_state)
  );

  uart_ovs_flags #(.DW(DW)) u_flags (
    .clk(clk), .rst_n(rst_n),
    .frame_done(frame_done), .frame_data(frame_data),
    .frame_stop_bad(frame_stop_bad), .frame_par_bad(frame_par_bad),
    .clr_full(clr_full), .clr_ovr(clr_ovr), .clr_fer(clr_fer), .clr_per(clr_per),
    .data_o(rx_data), .full_o(rx_full), .ovr_o(err_ovr), .fer_o(err_fer), .per_o(err_per)
  );

  a_r9_off_no_frame: assert property (@(posedge clk) disable iff (!rst_n)
    (!rx_en && $past(!rx_en)) |-> !frame_done);
  a_r2_idle_state_legal: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |-> (eng_state == ST_IDLE));
endmodule

// File: tb/uart_ovs_rx_tb_top.sv
module uart_ovs_rx_tb_top;
  localparam int BIT = 32;

  logic clk = 1'b0, rst_n = 1'b0, tick = 1'b0, rxd = 1'b1, rx_en = 1'b1;
  logic par_en = 1'b0, par_odd = 1'b0;
  logic clr_full = 1'b0, clr_ovr = 1'b0, clr_fer = 1'b0, clr_per = 1'b0;
  logic [7:0] rx_data;
  logic rx_full, err_ovr, err_fer, err_per;
  int checks = 0, failures = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;
  always @(negedge clk) tick <= ~tick;

  uart_ovs_rx dut_i (
    .clk(clk), .rst_n(rst_n), .tick(tick), .rxd(rxd), .rx_en(rx_en),
    .par_en(par_en), .par_odd(par_odd), .clr_full(clr_full), .clr_ovr(clr_ovr),
    .clr_fer(clr_fer), .clr_per(clr_per), .rx_data(rx_data), .rx_full(rx_full),
    .err_ovr(err_ovr), .err_fer(err_fer), .err_per(err_per)
  );

  // {par_en, par_odd, flip_parity, data}
  localparam logic [10:0] VEC [6] = '{
    {1'b0, 1'b0, 1'b0, 8'hA5},
    {1'b1, 1'b0, 1'b0, 8'h3C},
    {1'b1, 1'b1, 1'b0, 8'h81},
    {1'b1, 1'b0, 1'b1, 8'h7E},
    {1'b1, 1'b1, 1'b1, 8'h00},
    {1'b0, 1'b0, 1'b0, 8'hFF}
  };

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse(input bit f, input bit o, input bit e, input bit p);
    clr_full = f; clr_ovr = o; clr_fer = e; clr_per = p;
    wait_clk(1);
    clr_full = 0; clr_ovr = 0; clr_fer = 0; clr_per = 0;
    wait_clk(1);
  endtask

  task automatic send_bit(input logic b, input int len);
    rxd = b;
    wait_clk(len);
  endtask

  // frame: start, 8 data LSB first, optional parity, stop
  task automatic send_frame(input logic [7:0] d, input bit with_par, input logic pbit,
                            input logic stop_lvl);
    send_bit(1'b0, BIT);
    for (int i = 0; i < 8; i++) send_bit(d[i], BIT);
    if (with_par) send_bit(pbit, BIT);
    send_bit(stop_lvl, stop_lvl ? BIT : 24);
    send_bit(1'b1, BIT);
  endtask

  task automatic report();
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    #(200000 * 5);
    if (!finished) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired actual=1 expected=0");
      report();
    end
  end

  initial begin
    logic pb;
    wait_clk(4);
    // R1 reset state
    check("R1 full", rx_full, 0);
    check("R1 ovr", err_ovr, 0);
    check("R1 fer", err_fer, 0);
    check("R1 per", err_per, 0);
    check("R1 data", rx_data, 0);
    rst_n = 1'b1;
    wait_clk(BIT);

    // vector table: R2, R4
    for (int v = 0; v < 6; v++) begin
      par_en  = VEC[v][10];
      par_odd = VEC[v][9];
      pulse(1, 1, 1, 1);
      pb = (^VEC[v][7:0]) ^ VEC[v][9] ^ VEC[v][8];
      send_frame(VEC[v][7:0], VEC[v][10], pb, 1'b1);
      check("R2 data", rx_data, VEC[v][7:0]);
      check("R2 full", rx_full, 1);
      check("R4 per", err_per, VEC[v][10] & VEC[v][8]);
      check("R5 fer clean", err_fer, 0);
    end

    // R10 clear full
    pulse(1, 0, 0, 0);
    check("R10 full cleared", rx_full, 0);

    // R7 per sticky through other strobes, then own strobe
    pulse(1, 1, 0, 1);
    par_en = 1'b1; par_odd = 1'b0;
    send_frame(8'h0F, 1'b1, 1'b1, 1'b1);
    check("R4 even mismatch", err_per, 1);
    pulse(1, 1, 1, 0);
    check("R7 per kept on other strobes", err_per, 1);
    pulse(0, 0, 0, 1);
    check("R7 per own clear", err_per, 0);
    par_en = 1'b0;

    // R3 false start
    pulse(1, 1, 1, 1);
    send_bit(1'b0, 8);
    send_bit(1'b1, 12 * BIT);
    check("R3 false start no frame", rx_full, 0);
    check("R3 false start no fer", err_fer, 0);

    // R6 overrun
    send_frame(8'h55, 1'b0, 1'b0, 1'b1);
    send_frame(8'hC3, 1'b0, 1'b0, 1'b0);
    check("R6 ovr set", err_ovr, 1);
    check("R6 data kept", rx_data, 8'h55);
    check("R6 fer unchanged", err_fer, 0);
    wait_clk(3 * BIT);
    pulse(1, 0, 1, 1);
    check("R7 ovr sticky", err_ovr, 1);
    pulse(0, 1, 0, 0);
    check("R7 ovr own clear", err_ovr, 0);

    // R5 framing error
    pulse(1, 1, 1, 1);
    send_frame(8'h96, 1'b0, 1'b0, 1'b0);
    check("R5 fer set", err_fer, 1);
    check("R5 data loaded", rx_data, 8'h96);

    // R9 disable keeps flags, no reception
    pulse(1, 0, 0, 0);
    rx_en = 1'b0;
    wait_clk(4);
    check("R9 fer kept", err_fer, 1);
    send_frame(8'h3A, 1'b0, 1'b0, 1'b1);
    check("R9 no frame when off", rx_full, 0);
    check("R9 data kept", rx_data, 8'h96);
    check("R9 fer still kept", err_fer, 1);
    rx_en = 1'b1;
    wait_clk(BIT);

    // R8 break
    pulse(1, 1, 1, 1);
    rxd = 1'b0;
    wait_clk(12 * BIT);
    check("R8 break fer", err_fer, 1);
    check("R8 break full", rx_full, 1);
    check("R8 break data", rx_data, 0);
    pulse(1, 0, 1, 0);
    check("R8 fer cleared", err_fer, 0);
    wait_clk(10 * BIT);
    check("R8 fer reasserted", err_fer, 1);
    rxd = 1'b1;
    wait_clk(12 * BIT);
    pulse(1, 1, 1, 1);

    finished = 1'b1;
    report();
  end
endmodule